// File: doc/BRIEF.md
# Transfer Data Path for a Two-Wire Bus Master

This block sits beside a two-wire bus master sequencer. It supplies the bytes that the sequencer sends and puts away the bytes that it receives. Each byte can come from one of three places: a single byte register, a window of a shared byte pool, or memory reached through a simple one-byte-per-beat DMA port. The sequencer issues one command at a time. A command is an address fetch for a START, a data send, or a data receive. Four mode flags travel with the command and pick the source. The block runs the command to the end, a NAK or a memory error, and then reports completion.

The block holds the pool control register, the byte register, and the DMA pointer and length registers. Software loads these through a small write port. Software also has its own port into the pool. Counts in the pool control register are kept minus one. In pool mode, the first byte of the window is the slave address, so data begins at the second byte. Buffered or DMA commands are refused while the global SRAM enable is low.

Top module: `xfer_datapath`

## Requirements
- R1: The cmd_mode flags correspond to command word bits 6 to 9. cmd_mode[0] (bit 6) selects pool send, [1] (bit 7) pool receive, [2] (bit 8) DMA send and [3] (bit 9) DMA receive. For each direction, pool wins over DMA and DMA wins over the byte register.
- R2: reg_sel codes are 0 pool control, 1 byte register, 2 DMA pointer and 3 DMA length. A software write to pool control changes only bits 23:0. A byte register write stores wdata[7:0] in bits 7:0 and clears bits 15:8. A DMA pointer write forces bits 1:0 to zero. The DMA length keeps 12 bits.
- R3: An address command (cmd_op 0) sends one byte. That byte is pool window slot 0 in pool mode, one DMA byte in DMA mode, or byte register bits 7:0 otherwise.
- R4: A pool send that follows a pool address command starts at window index 1 and runs through the index held in pool control bits 15:8 (count minus one). A value of 0 in that field sends no data.
- R5: Each DMA beat that completes without error adds one to the pointer and subtracts one from the length. A DMA transfer runs until the length is zero. A DMA command issued with length zero moves nothing.
- R6: A pool or DMA send stops at the first NAK, and done_nak is raised with done.
- R7: A pool receive (cmd_op 2) fills window slots from index 0 up to the size held in bits 23:16 (size minus one). It then writes the number of bytes received into bits 31:24. A byte-mode receive places the byte in byte register bits 15:8 and clears bits 7:0. A DMA receive writes each byte to memory.
- R8: At the end of a send or receive, the mode flag of the pool or DMA source that was used clears in mode_en. An address command leaves mode_en unchanged.
- R9: If sram_en is low and any mode flag is set, cmd_rej pulses and nothing is transferred. Byte-mode commands still run.
- R10: A pool index past the end of the pool is clamped to the last slot.
- R11: A DMA beat answered with mem_err ends the command with done_err. That beat does not change the pointer or the length, and the mode flag clears.
- R12: A software write to pool control in the same cycle as the received-count update keeps both: bits 23:0 take the written value and bits 31:24 take the count.
- R13: out_data holds stable while out_valid waits for out_ack. At most one of out_valid, in_req and mem_req is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sram_en | input | 1 | Global SRAM enable |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| pool_ctrl | output | 32 | Pool control register |
| byte_buf | output | 16 | Byte register (send 7:0, receive 15:8) |
| dma_addr | output | ADDR_W | DMA pointer |
| dma_len | output | LEN_W | DMA remaining length |
| pool_we | input | 1 | Software pool write |
| pool_waddr | input | log2(POOL_DEPTH) | Software pool write slot |
| pool_wdata | input | 8 | Software pool write byte |
| pool_raddr | input | log2(POOL_DEPTH) | Software pool read slot |
| pool_rdata | output | 8 | Software pool read byte |
| cmd_go | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 address, 1 send, 2 receive |
| cmd_mode | input | 4 | Mode flags (command bits 9:6) |
| cmd_rej | output | 1 | Command refused |
| busy | output | 1 | Command in progress |
| mode_en | output | 4 | Live mode flags |
| done | output | 1 | Command finished pulse |
| done_nak | output | 1 | Finished on NAK |
| done_err | output | 1 | Finished on memory error |
| out_valid | output | 1 | Byte offered to sequencer |
| out_data | output | 8 | Byte to send |
| out_ack | input | 1 | Byte taken |
| out_nak | input | 1 | Byte was not acknowledged |
| in_req | output | 1 | Request for a received byte |
| in_valid | input | 1 | Received byte present |
| in_data | input | 8 | Received byte |
| mem_req | output | 1 | DMA beat request |
| mem_we | output | 1 | DMA beat is a write |
| mem_addr | output | ADDR_W | DMA beat address |
| mem_wdata | output | 8 | DMA write byte |
| mem_rdata | input | 8 | DMA read byte |
| mem_ready | input | 1 | DMA beat complete |
| mem_err | input | 1 | DMA beat error |

## Verification
The pool receive engine writes the received count into the top byte of pool control in the cycle it takes the last byte. A software write to that same register can arrive in that cycle. The bench provokes this by having its byte responder raise a pool control write at the moment it hands over the final byte of a three-byte receive. The check then expects the written low 24 bits and a count of three together in one read. A separate property watches that no other software write disturbs the count field.

// File: rtl/xdp_pkg.sv
package xdp_pkg;

  typedef enum logic [1:0] {
    OP_ADDR = 2'd0,
    OP_SEND = 2'd1,
    OP_RECV = 2'd2,
    OP_NONE = 2'd3
  } xdp_op_e;

  typedef enum logic [1:0] {
    SRC_BYTE = 2'd0,
    SRC_POOL = 2'd1,
    SRC_DMA  = 2'd2
  } xdp_src_e;

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_MRD, S_SEND, S_RECV, S_MWR, S_DONE
  } xdp_state_e;

  localparam int MF_TXPOOL = 0;
  localparam int MF_RXPOOL = 1;
  localparam int MF_TXDMA  = 2;
  localparam int MF_RXDMA  = 3;

  localparam logic [1:0] SEL_POOL  = 2'd0;
  localparam logic [1:0] SEL_BYTE  = 2'd1;
  localparam logic [1:0] SEL_DADDR = 2'd2;
  localparam logic [1:0] SEL_DLEN  = 2'd3;

  function automatic xdp_src_e pick_src(logic [3:0] flags, logic is_rx);
    if (is_rx) begin
      if (flags[MF_RXPOOL]) return SRC_POOL;
      if (flags[MF_RXDMA])  return SRC_DMA;
    end else begin
      if (flags[MF_TXPOOL]) return SRC_POOL;
      if (flags[MF_TXDMA])  return SRC_DMA;
    end
    return SRC_BYTE;
  endfunction

  function automatic int unsigned slot_clamp(int unsigned ofs, int unsigned idx,
                                             int unsigned depth);
    return (ofs + idx >= depth) ? depth - 1 : ofs + idx;
  endfunction

  function automatic logic [8:0] field_total(logic [7:0] stored);
    return {1'b0, stored} + 9'd1;
  endfunction

  function automatic int unsigned flag_of(xdp_op_e op, xdp_src_e src);
    if (op == OP_RECV) return (src == SRC_POOL) ? MF_RXPOOL : MF_RXDMA;
    return (src == SRC_POOL) ? MF_TXPOOL : MF_TXDMA;
  endfunction

endpackage

// File: rtl/xdp_regs.sv
module xdp_regs
  import xdp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr,
  input  logic [1:0]        sw_sel,
  input  logic [31:0]       sw_wdata,
  input  logic              cnt_wr,
  input  logic [7:0]        cnt_val,
  input  logic              rxb_wr,
  input  logic [7:0]        rxb_val,
  input  logic              dma_step,
  output logic [31:0]       pool_ctrl,
  output logic [15:0]       byte_buf,
  output logic [ADDR_W-1:0] dma_addr,
  output logic [LEN_W-1:0]  dma_len
);

  logic wr_pool, wr_byte, wr_daddr, wr_dlen;
  assign wr_pool  = sw_wr && (sw_sel == SEL_POOL);
  assign wr_byte  = sw_wr && (sw_sel == SEL_BYTE);
  assign wr_daddr = sw_wr && (sw_sel == SEL_DADDR);
  assign wr_dlen  = sw_wr && (sw_sel == SEL_DLEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pool_ctrl <= '0;
      byte_buf  <= '0;
      dma_addr  <= '0;
      dma_len   <= '0;
    end else begin
      if (wr_pool) pool_ctrl[23:0]  <= sw_wdata[23:0];
      if (cnt_wr)  pool_ctrl[31:24] <= cnt_val;
      if (wr_byte)     byte_buf <= {8'h00, sw_wdata[7:0]};
      else if (rxb_wr) byte_buf <= {rxb_val, 8'h00};
      if (wr_daddr)      dma_addr <= {sw_wdata[ADDR_W-1:2], 2'b00};
      else if (dma_step) dma_addr <= dma_addr + 1'b1;
      if (wr_dlen)       dma_len <= sw_wdata[LEN_W-1:0];
      else if (dma_step) dma_len <= dma_len - 1'b1;
    end
  end

endmodule

// File: rtl/xdp_pool.sv
module xdp_pool #(
  parameter int POOL_DEPTH = 32,
  localparam int PW = $clog2(POOL_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_we,
  input  logic [PW-1:0] sw_waddr,
  input  logic [7:0]    sw_wdata,
  input  logic [PW-1:0] sw_raddr,
  output logic [7:0]    sw_rdata,
  input  logic          eng_we,
  input  logic [PW-1:0] eng_slot,
  input  logic [7:0]    eng_wdata,
  output logic [7:0]    eng_rdata
);

  logic [7:0] cells [POOL_DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < POOL_DEPTH; i++) cells[i] <= '0;
    end else begin
      if (sw_we)  cells[sw_waddr] <= sw_wdata;
      if (eng_we) cells[eng_slot] <= eng_wdata;
    end
  end

  assign sw_rdata  = cells[sw_raddr];
  assign eng_rdata = cells[eng_slot];

endmodule

// File: rtl/xdp_engine.sv
module xdp_engine
  import xdp_pkg::*;
#(
  parameter int POOL_DEPTH = 32,
  parameter int POOL_OFS   = 16,
  parameter int LEN_W      = 12,
  localparam int PW = $clog2(POOL_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sram_en,
  input  logic             cmd_go,
  input  logic [1:0]       cmd_op,
  input  logic [3:0]       cmd_mode,
  output logic             cmd_rej,
  output logic             busy,
  output logic [3:0]       mode_en,
  output logic             done,
  output logic             done_nak,
  output logic             done_err,
  input  logic [7:0]       tx_cnt_f,
  input  logic [7:0]       rx_size_f,
  input  logic [7:0]       byte_tx,
  input  logic [LEN_W-1:0] dma_len,
  output logic [PW-1:0]    pool_slot,
  output logic             pool_we,
  output logic [7:0]       pool_wdata,
  input  logic [7:0]       pool_rdata,
  output logic             cnt_wr,
  output logic [7:0]       cnt_val,
  output logic             rxb_wr,
  output logic [7:0]       rxb_val,
  output logic             dma_step,
  output logic             out_valid,
  output logic [7:0]       out_data,
  input  logic             out_ack,
  input  logic             out_nak,
  output logic             in_req,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             mem_req,
  output logic             mem_we,
  output logic [7:0]       mem_wdata,
  input  logic [7:0]       mem_rdata,
  input  logic             mem_ready,
  input  logic             mem_err
);

  xdp_state_e st;
  xdp_op_e    op_q;
  xdp_src_e   src_q;
  logic [8:0] idx_q;
  logic [7:0] data_q;
  logic       skip_q, nak_q, err_q;

  xdp_op_e    go_op;
  xdp_src_e   go_src;
  logic       go_ok;
  logic [8:0] tx_total, rx_total, idx_nx, tx_first;
  logic       len_zero, len_one, beat_ok;

  assign go_op    = xdp_op_e'(cmd_op);
  assign go_src   = pick_src(cmd_mode, go_op == OP_RECV);
  assign cmd_rej  = cmd_go && (st == S_IDLE) && !sram_en && (|cmd_mode);
  assign go_ok    = cmd_go && (st == S_IDLE) && !cmd_rej;
  assign tx_total = field_total(tx_cnt_f);
  assign rx_total = field_total(rx_size_f);
  assign idx_nx   = idx_q + 9'd1;
  assign tx_first = skip_q ? 9'd1 : 9'd0;
  assign len_zero = (dma_len == '0);
  assign len_one  = (dma_len == LEN_W'(1));

  assign pool_slot  = PW'(slot_clamp(POOL_OFS, int'(idx_q), POOL_DEPTH));
  assign out_valid  = (st == S_SEND);
  assign out_data   = data_q;
  assign in_req     = (st == S_RECV);
  assign mem_req    = (st == S_MRD) || (st == S_MWR);
  assign mem_we     = (st == S_MWR);
  assign mem_wdata  = data_q;
  assign beat_ok    = mem_req && mem_ready && !mem_err;
  assign dma_step   = beat_ok;
  assign pool_we    = in_req && in_valid && (src_q == SRC_POOL);
  assign pool_wdata = in_data;
  assign cnt_wr     = pool_we && (idx_nx >= rx_total);
  assign cnt_val    = idx_nx[7:0];
  assign rxb_wr     = in_req && in_valid && (src_q == SRC_BYTE);
  assign rxb_val    = in_data;
  assign busy       = (st != S_IDLE);
  assign done       = (st == S_DONE);
  assign done_nak   = done && nak_q;
  assign done_err   = done && err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      op_q    <= OP_NONE;
      src_q   <= SRC_BYTE;
      idx_q   <= '0;
      data_q  <= '0;
      skip_q  <= 1'b0;
      nak_q   <= 1'b0;
      err_q   <= 1'b0;
      mode_en <= '0;
    end else begin
      case (st)
        S_IDLE: if (go_ok) begin
          mode_en <= cmd_mode;
          op_q    <= go_op;
          src_q   <= go_src;
          nak_q   <= 1'b0;
          err_q   <= 1'b0;
          idx_q   <= '0;
          data_q  <= byte_tx;
          skip_q  <= (go_op == OP_ADDR) && (go_src == SRC_POOL);
          case (go_op)
            OP_ADDR: case (go_src)
              SRC_POOL: st <= S_LOAD;
              SRC_DMA:  st <= len_zero ? S_DONE : S_MRD;
              default:  st <= S_SEND;
            endcase
            OP_SEND: begin
              idx_q <= tx_first;
              case (go_src)
                SRC_POOL: st <= (tx_first >= tx_total) ? S_DONE : S_LOAD;
                SRC_DMA:  st <= len_zero ? S_DONE : S_MRD;
                default:  st <= S_SEND;
              endcase
            end
            OP_RECV:
              st <= (go_src == SRC_DMA && len_zero) ? S_DONE : S_RECV;
            default: st <= S_DONE;
          endcase
        end
        S_LOAD: begin
          data_q <= pool_rdata;
          st     <= S_SEND;
        end
        S_MRD: if (mem_ready) begin
          if (mem_err) begin
            err_q <= 1'b1;
            st    <= S_DONE;
          end else begin
            data_q <= mem_rdata;
            st     <= S_SEND;
          end
        end
        S_SEND: if (out_ack) begin
          if (out_nak) begin
            nak_q <= 1'b1;
            st    <= S_DONE;
          end else if (op_q == OP_ADDR) begin
            st <= S_DONE;
          end else begin
            case (src_q)
              SRC_POOL: begin
                idx_q <= idx_nx;
                st    <= (idx_nx >= tx_total) ? S_DONE : S_LOAD;
              end
              SRC_DMA: st <= len_zero ? S_DONE : S_MRD;
              default: st <= S_DONE;
            endcase
          end
        end
        S_RECV: if (in_valid) begin
          case (src_q)
            SRC_POOL: begin
              idx_q <= idx_nx;
              if (idx_nx >= rx_total) st <= S_DONE;
            end
            SRC_DMA: begin
              data_q <= in_data;
              st     <= S_MWR;
            end
            default: st <= S_DONE;
          endcase
        end
        S_MWR: if (mem_ready) begin
          if (mem_err) begin
            err_q <= 1'b1;
            st    <= S_DONE;
          end else begin
            st <= len_one ? S_DONE : S_RECV;
          end
        end
        S_DONE: begin
          if ((op_q == OP_SEND || op_q == OP_RECV || err_q) && src_q != SRC_BYTE)
            mode_en[flag_of(op_q, src_q)] <= 1'b0;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/xfer_datapath.sv
module xfer_datapath
  import xdp_pkg::*;
#(
  parameter int POOL_DEPTH = 32,
  parameter int POOL_OFS   = 16,
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sram_en,
  input  logic                          reg_wr,
  input  logic [1:0]                    reg_sel,
  input  logic [31:0]                   reg_wdata,
  output logic [31:0]                   pool_ctrl,
  output logic [15:0]                   byte_buf,
  output logic [ADDR_W-1:0]             dma_addr,
  output logic [LEN_W-1:0]              dma_len,
  input  logic                          pool_we,
  input  logic [$clog2(POOL_DEPTH)-1:0] pool_waddr,
  input  logic [7:0]                    pool_wdata,
  input  logic [$clog2(POOL_DEPTH)-1:0] pool_raddr,
  output logic [7:0]                    pool_rdata,
  input  logic                          cmd_go,
  input  logic [1:0]                    cmd_op,
  input  logic [3:0]                    cmd_mode,
  output logic                          cmd_rej,
  output logic                          busy,
  output logic [3:0]                    mode_en,
  output logic                          done,
  output logic                          done_nak,
  output logic                          done_err,
  output logic                          out_valid,
  output logic [7:0]                    out_data,
  input  logic                          out_ack,
  input  logic                          out_nak,
  output logic                          in_req,
  input  logic                          in_valid,
  input  logic [7:0]                    in_data,
  output logic                          mem_req,
  output logic                          mem_we,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic [7:0]                    mem_wdata,
  input  logic [7:0]                    mem_rdata,
  input  logic                          mem_ready,
  input  logic                          mem_err
);

  localparam int PW = $clog2(POOL_DEPTH);

  logic [PW-1:0] eng_slot;
  logic          eng_we;
  logic [7:0]    eng_wdata, eng_rdata;
  logic          cnt_wr, rxb_wr, dma_step;
  logic [7:0]    cnt_val, rxb_val;

  assign mem_addr = dma_addr;

  xdp_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .sw_wr(reg_wr), .sw_sel(reg_sel), .sw_wdata(reg_wdata),
    .cnt_wr(cnt_wr), .cnt_val(cnt_val),
    .rxb_wr(rxb_wr), .rxb_val(rxb_val),
    .dma_step(dma_step),
    .pool_ctrl(pool_ctrl), .byte_buf(byte_buf),
    .dma_addr(dma_addr), .dma_len(dma_len)
  );

  xdp_pool #(.POOL_DEPTH(POOL_DEPTH)) u_pool (
    .clk(clk), .rst_n(rst_n),
    .sw_we(pool_we), .sw_waddr(pool_waddr), .sw_wdata(pool_wdata),
    .sw_raddr(pool_raddr), .sw_rdata(pool_rdata),
    .eng_we(eng_we), .eng_slot(eng_slot), .eng_wdata(eng_wdata),
    .eng_rdata(eng_rdata)
  );

  xdp_engine #(.POOL_DEPTH(POOL_DEPTH), .POOL_OFS(POOL_OFS), .LEN_W(LEN_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .sram_en(sram_en),
    .cmd_go(cmd_go), .cmd_op(cmd_op), .cmd_mode(cmd_mode),
    .cmd_rej(cmd_rej), .busy(busy), .mode_en(mode_en),
    .done(done), .done_nak(done_nak), .done_err(done_err),
    .tx_cnt_f(pool_ctrl[15:8]), .rx_size_f(pool_ctrl[23:16]),
    .byte_tx(byte_buf[7:0]), .dma_len(dma_len),
    .pool_slot(eng_slot), .pool_we(eng_we), .pool_wdata(eng_wdata),
    .pool_rdata(eng_rdata),
    .cnt_wr(cnt_wr), .cnt_val(cnt_val),
    .rxb_wr(rxb_wr), .rxb_val(rxb_val), .dma_step(dma_step),
    .out_valid(out_valid), .out_data(out_data), .out_ack(out_ack), .out_nak(out_nak),
    .in_req(in_req), .in_valid(in_valid), .in_data(in_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .mem_err(mem_err)
  );

endmodule

// File: rtl/xfer_datapath_chk.sv
module xfer_datapath_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [1:0]        reg_sel,
  input logic [31:0]       pool_ctrl,
  input logic [ADDR_W-1:0] dma_addr,
  input logic [LEN_W-1:0]  dma_len,
  input logic              cnt_wr,
  input logic              dma_step,
  input logic              cmd_rej,
  input logic              busy,
  input logic [3:0]        mode_en,
  input logic              done,
  input logic              done_nak,
  input logic              done_err,
  input logic              out_valid,
  input logic [7:0]        out_data,
  input logic              out_ack,
  input logic              out_nak,
  input logic              in_req,
  input logic              mem_req,
  input logic              mem_ready,
  input logic              mem_err
);

  // R13
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ack |=> out_valid && $stable(out_data));

  // R13
  one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_valid, in_req, mem_req}));

  // R9
  reject_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rej |=> !busy && $stable(mode_en));

  // R2
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_sel == 2'd2 |=> dma_addr[1:0] == 2'b00);

  // R5
  dma_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_step && !(reg_wr && reg_sel[1]) |=>
      dma_addr == $past(dma_addr) + 1'b1 && dma_len == $past(dma_len) - 1'b1);

  // R2
  count_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_sel == 2'd0 && !cnt_wr |=> pool_ctrl[31:24] == $past(pool_ctrl[31:24]));

  // R6
  nak_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ack && out_nak |=> done && done_nak);

  // R11
  err_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ready && mem_err |=> done && done_err);

endmodule

bind xfer_datapath xfer_datapath_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .pool_ctrl(pool_ctrl), .dma_addr(dma_addr), .dma_len(dma_len),
  .cnt_wr(cnt_wr), .dma_step(dma_step), .cmd_rej(cmd_rej), .busy(busy),
  .mode_en(mode_en), .done(done), .done_nak(done_nak), .done_err(done_err),
  .out_valid(out_valid), .out_data(out_data), .out_ack(out_ack), .out_nak(out_nak),
  .in_req(in_req), .mem_req(mem_req), .mem_ready(mem_ready), .mem_err(mem_err)
);

// File: tb/xfer_datapath_test.sv
`timescale 1ns/1ps
module xfer_datapath_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        sram_en = 1'b1;
  logic        sw_wr = 1'b0, conc_wr = 1'b0;
  logic [1:0]  sw_sel = 2'd0;
  logic [31:0] sw_data = '0, conc_data = '0;
  logic        reg_wr;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic [31:0] pool_ctrl;
  logic [15:0] byte_buf;
  logic [31:0] dma_addr;
  logic [11:0] dma_len;
  logic        pool_we = 1'b0;
  logic [4:0]  pool_waddr = '0, pool_raddr = '0;
  logic [7:0]  pool_wdata = '0, pool_rdata;
  logic        cmd_go = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [3:0]  cmd_mode = '0;
  logic        cmd_rej, busy, done, done_nak, done_err;
  logic [3:0]  mode_en;
  logic        out_valid, out_ack = 1'b0, out_nak = 1'b0;
  logic [7:0]  out_data;
  logic        in_req, in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        mem_req, mem_we, mem_ready = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata = '0;

  assign reg_wr    = sw_wr | conc_wr;
  assign reg_sel   = conc_wr ? 2'd0 : sw_sel;
  assign reg_wdata = conc_wr ? conc_data : sw_data;

  xfer_datapath uut (
    .clk(clk), .rst_n(rst_n), .sram_en(sram_en),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .pool_ctrl(pool_ctrl), .byte_buf(byte_buf), .dma_addr(dma_addr), .dma_len(dma_len),
    .pool_we(pool_we), .pool_waddr(pool_waddr), .pool_wdata(pool_wdata),
    .pool_raddr(pool_raddr), .pool_rdata(pool_rdata),
    .cmd_go(cmd_go), .cmd_op(cmd_op), .cmd_mode(cmd_mode), .cmd_rej(cmd_rej),
    .busy(busy), .mode_en(mode_en), .done(done), .done_nak(done_nak), .done_err(done_err),
    .out_valid(out_valid), .out_data(out_data), .out_ack(out_ack), .out_nak(out_nak),
    .in_req(in_req), .in_valid(in_valid), .in_data(in_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .mem_err(mem_err)
  );

  int errors = 0, checks = 0;
  logic [7:0] tx_log [32];
  int   tx_n = 0, rx_n = 0, nak_at = -1, conc_at = -1;
  logic [7:0] rx_seed = 8'hA0, err_addr = 8'h00;
  logic err_on = 1'b0;
  logic [7:0] bmem [256];
  logic seen_rej, seen_nak, seen_err;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // responders: bus byte side and DMA memory, driven away from the active edge
  always @(negedge clk) begin
    conc_wr = 1'b0;
    if (out_valid) begin
      out_ack = 1'b1;
      out_nak = (tx_n == nak_at);
      tx_log[tx_n[4:0]] = out_data;
      tx_n++;
    end else begin
      out_ack = 1'b0;
      out_nak = 1'b0;
    end
    if (in_req) begin
      in_valid = 1'b1;
      in_data  = rx_seed + 8'(rx_n);
      if (rx_n == conc_at) conc_wr = 1'b1;
      rx_n++;
    end else begin
      in_valid = 1'b0;
    end
    if (mem_req) begin
      mem_ready = 1'b1;
      mem_err   = err_on && (mem_addr[7:0] == err_addr);
      if (!mem_err && mem_we) bmem[mem_addr[7:0]] = mem_wdata;
      mem_rdata = bmem[mem_addr[7:0]];
    end else begin
      mem_ready = 1'b0;
      mem_err   = 1'b0;
    end
  end

  task automatic wreg(logic [1:0] sel, logic [31:0] d);
    @(negedge clk);
    sw_wr = 1'b1; sw_sel = sel; sw_data = d;
    @(negedge clk);
    sw_wr = 1'b0;
  endtask

  task automatic wpool(int slot, logic [7:0] d);
    @(negedge clk);
    pool_we = 1'b1; pool_waddr = 5'(slot); pool_wdata = d;
    @(negedge clk);
    pool_we = 1'b0;
  endtask

  task automatic rpool(int slot, output logic [7:0] d);
    pool_raddr = 5'(slot);
    #1 d = pool_rdata;
  endtask

  task automatic issue(logic [1:0] op, logic [3:0] mode);
    tx_n = 0; rx_n = 0;
    seen_nak = 1'b0; seen_err = 1'b0;
    @(negedge clk);
    cmd_go = 1'b1; cmd_op = op; cmd_mode = mode;
    #1 seen_rej = cmd_rej;
    @(negedge clk);
    cmd_go = 1'b0;
    if (!seen_rej) begin
      for (int k = 0; k < 3000; k++) begin
        #1;
        if (done) begin
          seen_nak = done_nak; seen_err = done_err;
          break;
        end
        @(negedge clk);
      end
    end
    @(negedge clk);
  endtask

  function automatic logic [31:0] rd(logic [1:0] sel);
    case (sel)
      2'd0: return pool_ctrl;
      2'd1: return {16'h0, byte_buf};
      2'd2: return dma_addr;
      default: return {20'h0, dma_len};
    endcase
  endfunction

  // {sel, write data, expected read}
  localparam logic [65:0] REG_VEC [6] = '{
    {2'd0, 32'hFFFF_FFFF, 32'h00FF_FFFF},
    {2'd0, 32'h1203_0400, 32'h0003_0400},
    {2'd1, 32'h0000_ABCD, 32'h0000_00CD},
    {2'd2, 32'h1234_5677, 32'h1234_5674},
    {2'd3, 32'h0000_F005, 32'h0000_0005},
    {2'd3, 32'h0000_1FFF, 32'h0000_0FFF}
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] pv;
    for (int i = 0; i < 256; i++) bmem[i] = 8'(i + 8'h30);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk("R2 reset pool_ctrl", pool_ctrl, 0);
    chk("R2 reset byte_buf", {16'h0, byte_buf}, 0);
    chk("R5 reset dma", {dma_addr[19:0], dma_len}, 0);
    chk("R8 reset mode_en/busy", {27'h0, mode_en, busy}, 0);
    chk("R13 reset idle handshakes", {29'h0, out_valid, in_req, mem_req}, 0);

    // register write vectors (R2)
    for (int i = 0; i < 6; i++) begin
      wreg(REG_VEC[i][65:64], REG_VEC[i][63:32]);
      chk("R2 register write mask", rd(REG_VEC[i][65:64]), REG_VEC[i][31:0]);
    end

    // byte-mode address (R3)
    wreg(2'd1, 32'h5A);
    issue(2'd0, 4'b0000);
    chk("R3 byte address count", tx_n, 1);
    chk("R3 byte address value", tx_log[0], 8'h5A);

    // pool address then pool send (R3 R4 R8)
    for (int i = 0; i < 4; i++) wpool(16 + i, 8'(8'h10 + i));
    wreg(2'd0, 32'h0000_0300);
    issue(2'd0, 4'b0001);
    chk("R3 pool address byte", tx_log[0], 8'h10);
    chk("R8 address keeps flag", mode_en, 4'b0001);
    issue(2'd1, 4'b0001);
    chk("R4 pool send count", tx_n, 3);
    chk("R4 pool send bytes", {tx_log[0], tx_log[1], tx_log[2]}, 24'h111213);
    chk("R8 pool send clears flag", mode_en, 4'b0000);

    // count field zero: no data phase (R4)
    wreg(2'd0, 32'h0);
    issue(2'd0, 4'b0001);
    issue(2'd1, 4'b0001);
    chk("R4 single-count send empty", tx_n, 0);
    chk("R8 empty send clears flag", mode_en, 4'b0000);

    // NAK on second data byte (R6)
    wreg(2'd0, 32'h0000_0300);
    issue(2'd0, 4'b0001);
    nak_at = 1;
    issue(2'd1, 4'b0001);
    nak_at = -1;
    chk("R6 stop at nak count", tx_n, 2);
    chk("R6 done_nak", seen_nak, 1);

    // priority: pool over DMA (R1)
    wreg(2'd2, 32'h40);
    wreg(2'd3, 32'd3);
    issue(2'd0, 4'b0101);
    chk("R1 pool wins over dma byte", tx_log[0], 8'h10);
    chk("R1 dma untouched", {dma_addr[19:0], dma_len}, {20'h40, 12'd3});

    // DMA address + send (R3 R5 R8), pointer written unaligned
    wreg(2'd2, 32'h41);
    issue(2'd0, 4'b0100);
    chk("R3 dma address byte", tx_log[0], 8'h70);
    chk("R5 dma after address", {dma_addr[19:0], dma_len}, {20'h41, 12'd2});
    issue(2'd1, 4'b0100);
    chk("R5 dma send bytes", {tx_n[7:0], tx_log[0], tx_log[1]}, {8'd2, 16'h7172});
    chk("R5 dma send pointers", {dma_addr[19:0], dma_len}, {20'h43, 12'd0});
    chk("R8 dma send clears flag", mode_en, 4'b0000);

    // DMA receive (R7 R5)
    wreg(2'd2, 32'h80);
    wreg(2'd3, 32'd3);
    rx_seed = 8'hA0;
    issue(2'd2, 4'b1000);
    chk("R7 dma receive memory", {bmem[8'h80], bmem[8'h81], bmem[8'h82]}, 24'hA0A1A2);
    chk("R5 dma receive pointers", {dma_addr[19:0], dma_len}, {20'h83, 12'd0});
    chk("R8 dma receive clears flag", mode_en, 4'b0000);

    // DMA length zero moves nothing (R5)
    wreg(2'd2, 32'h90);
    wreg(2'd3, 32'd0);
    issue(2'd0, 4'b0100);
    chk("R5 zero length no bytes", tx_n, 0);
    chk("R5 zero length pointer", dma_addr, 32'h90);

    // DMA error abort on second beat (R11)
    wreg(2'd2, 32'h80);
    wreg(2'd3, 32'd4);
    rx_seed = 8'hC0; err_addr = 8'h81; err_on = 1'b1;
    issue(2'd2, 4'b1000);
    err_on = 1'b0;
    chk("R11 done_err", seen_err, 1);
    chk("R11 pointers at failed beat", {dma_addr[19:0], dma_len}, {20'h81, 12'd3});
    chk("R11 memory", {bmem[8'h80], bmem[8'h81]}, 16'hC0A1);
    chk("R11 flag cleared", mode_en, 4'b0000);

    // pool receive with concurrent pool control write on last byte (R7 R12)
    wreg(2'd0, 32'h0002_0000);
    rx_seed = 8'h50; conc_at = 2; conc_data = 32'h000A_0500;
    issue(2'd2, 4'b0010);
    conc_at = -1;
    rpool(16, pv); chk("R7 pool slot 0", pv, 8'h50);
    rpool(18, pv); chk("R7 pool slot 2", pv, 8'h52);
    chk("R12 count and write merge", pool_ctrl, 32'h030A_0500);
    chk("R8 pool receive clears flag", mode_en, 4'b0000);

    // byte-mode receive (R7)
    wreg(2'd1, 32'h33);
    rx_seed = 8'h9C;
    issue(2'd2, 4'b0000);
    chk("R7 byte receive placement", {16'h0, byte_buf}, 32'h9C00);

    // SRAM gate (R9)
    sram_en = 1'b0;
    wreg(2'd1, 32'h5A);
    issue(2'd0, 4'b0001);
    chk("R9 reject pulse", seen_rej, 1);
    chk("R9 nothing sent", {tx_n[7:0], 4'h0, mode_en}, 0);
    issue(2'd0, 4'b0000);
    chk("R9 byte mode still runs", {tx_n[7:0], tx_log[0]}, {8'd1, 8'h5A});
    sram_en = 1'b1;

    // clamp past pool end (R10): 20 bytes from slot 16 of 32
    wreg(2'd0, 32'h0013_0000);
    rx_seed = 8'h20;
    issue(2'd2, 4'b0010);
    rpool(30, pv); chk("R10 slot before end", pv, 8'h2E);
    rpool(31, pv); chk("R10 clamped last slot", pv, 8'h33);
    chk("R7 received count 20", pool_ctrl, 32'h1413_0000);

    summary();
  end

endmodule